// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind the serial protocol engine of a byte-addressed non-volatile memory. A write command opens a page session. The session takes its start address from the command. Each data byte that follows goes into a slot of a small page latch, picked by the low address bits. A per-slot valid mask records which slots this session loaded. Only those slots reach the array later.

Nothing reaches the array until the bus STOP is seen. At that point the block samples the write-protect level. If the level is high, or the session loaded nothing, the session closes and the block is ready at once. Otherwise a self-timed commit cycle starts and lasts a parameterised number of clock ticks. During the cycle `busy` stays high, and the protocol engine uses it to withhold acknowledges. In the first ticks of the cycle the loaded slots are written to the array, one per tick.

A repeated START that arrives in place of a STOP closes the session and discards the latch contents.

Top module: `pwb_page_commit`

## Requirements
- R1: After reset `busy` is low, `arr_we` is low, and no session is open.
- R2: Bytes are stored from slot `start_addr[4:0]` onward. After each byte only the 5-bit slot pointer advances, wrapping from 31 to 0. Every array address keeps `start_addr[12:5]` as its upper bits, and its lower 5 bits are the slot number.
- R3: When more than 32 bytes arrive in one session, the pointer wraps and a later byte replaces the earlier content of its slot. The array receives only the last value of each slot.
- R4: `arr_we` is never high outside a commit cycle, so nothing is written before STOP.
- R5: A committing STOP raises `busy` in the next cycle and holds it for exactly `CYCLE_TICKS` cycles. Tick k of the cycle (k = 0..31) writes slot k, if that slot was loaded. Writes therefore come out in ascending slot order.
- R6: If `wp` is high in the STOP cycle, `busy` stays low and nothing is written. A new command is accepted in the very next cycle.
- R7: Changes on `wp` while `busy` is high do not alter the running cycle or its writes.
- R8: Only slots loaded in the current session are written. The valid mask is cleared by every accepted `cmd_start`.
- R9: A `rstart` pulse during an open session closes it without any array write. A later STOP then starts nothing.
- R10: `cmd_start`, `byte_vld`, `stop` and `rstart` have no effect while `busy` is high. A STOP given after the cycle, with no new command, starts nothing.
- R11: A STOP in a session that loaded no byte starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Opens a write session; loads `start_addr` and clears the valid mask |
| start_addr | input | ADDR_W | Word address of the first data byte |
| byte_vld | input | 1 | One received data byte is present on `byte_data` |
| byte_data | input | DATA_W | Received data byte |
| stop | input | 1 | Bus STOP seen; decides commit or close |
| rstart | input | 1 | Repeated START seen; discards the session |
| wp | input | 1 | Write-protect level, sampled with `stop` |
| arr_we | output | 1 | Array write strobe, one per loaded slot |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Self-timed commit cycle in progress |

## Verification
The bench targets four kinds of corner case.

- Pointer wrap. It starts sessions near the top of a page and runs them past 32 bytes. A design that carried the wrap into the upper address bits would write outside the page. A design that did not overwrite would write stale data.
- The protect decision. It holds `wp` high at STOP, and separately flips `wp` in the middle of a cycle. A design that sampled `wp` at the wrong moment would write a protected page or abort a running cycle.
- Stale latch contents. It follows a discarded or short session with a smaller one. A mask that was never cleared would write old slots.
- Stray control traffic during `busy`. It sends commands and STOPs while a cycle runs. A design that obeyed them would lengthen or restart the cycle.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        PW_IDLE   = 2'd0,
        PW_FILL   = 2'd1,
        PW_COMMIT = 2'd2
    } pw_state_e;

endpackage

// File: rtl/pwb_page_latch.sv
module pwb_page_latch #(
    parameter int PAGE_BYTES = 32,
    parameter int DATA_W     = 8,
    localparam int SLOT_W    = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);

    typedef struct packed {
        logic [PAGE_BYTES-1:0][DATA_W-1:0] mem;
        logic [PAGE_BYTES-1:0]             mask;
    } latch_t;

    latch_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.mask = '0;
        end else if (wr_en) begin
            r_d.mem[wr_slot]  = wr_data;
            r_d.mask[wr_slot] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data   = r_q.mem[rd_slot];
    assign rd_valid  = r_q.mask[rd_slot];
    assign any_valid = |r_q.mask;

    // R8: a new session starts with an empty mask
    a_r8_mask_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (r_q.mask == '0));

    // R3: the slot just loaded is marked valid and holds the byte
    a_r3_slot_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (r_q.mask[$past(wr_slot)] &&
                            r_q.mem[$past(wr_slot)] == $past(wr_data)));

endmodule

// File: rtl/pwb_commit_timer.sv
module pwb_commit_timer #(
    parameter int CYCLE_TICKS = 5000,
    parameter int PAGE_BYTES  = 32,
    localparam int SLOT_W     = $clog2(PAGE_BYTES),
    localparam int CNT_W      = $clog2(CYCLE_TICKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              last,
    output logic              slot_live,
    output logic [SLOT_W-1:0] slot
);

    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(CYCLE_TICKS - 1);
    localparam logic [CNT_W-1:0] PAGE_CNT  = CNT_W'(PAGE_BYTES);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_q, t_d;

    always_comb begin
        t_d = t_q;
        if (t_q.run) begin
            if (t_q.cnt == LAST_TICK) begin
                t_d.run = 1'b0;
                t_d.cnt = '0;
            end else begin
                t_d.cnt = t_q.cnt + 1'b1;
            end
        end else if (start) begin
            t_d.run = 1'b1;
            t_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy      = t_q.run;
    assign last      = t_q.run && (t_q.cnt == LAST_TICK);
    assign slot_live = t_q.run && (t_q.cnt < PAGE_CNT);
    assign slot      = t_q.cnt[SLOT_W-1:0];

    // R5: the cycle ends right after its final tick
    a_r5_cycle_ends: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !busy);

    // R5: the cycle only begins on a start request
    a_r5_no_spurious_run: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);

    // R7: a running cycle cannot stop early
    a_r7_runs_to_end: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> busy);

endmodule

// File: rtl/pwb_page_commit.sv
module pwb_page_commit
    import pwb_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 32,
    parameter int CYCLE_TICKS = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop,
    input  logic              rstart,
    input  logic              wp,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              busy
);

    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam int HI_W   = ADDR_W - SLOT_W;

    typedef struct packed {
        pw_state_e         st;
        logic [HI_W-1:0]   hi;
        logic [SLOT_W-1:0] ptr;
    } ctl_t;

    ctl_t c_q, c_d;

    logic              lat_clr, lat_wr, lat_any, lat_rd_valid;
    logic [DATA_W-1:0] lat_rd_data;
    logic              tmr_start, tmr_busy, tmr_last, tmr_live;
    logic [SLOT_W-1:0] tmr_slot;

    always_comb begin
        c_d       = c_q;
        lat_clr   = 1'b0;
        lat_wr    = 1'b0;
        tmr_start = 1'b0;
        unique case (c_q.st)
            PW_IDLE: begin
                if (cmd_start) begin
                    c_d.st  = PW_FILL;
                    c_d.hi  = start_addr[ADDR_W-1:SLOT_W];
                    c_d.ptr = start_addr[SLOT_W-1:0];
                    lat_clr = 1'b1;
                end
            end
            PW_FILL: begin
                if (rstart) begin
                    c_d.st = PW_IDLE;
                end else if (cmd_start) begin
                    c_d.hi  = start_addr[ADDR_W-1:SLOT_W];
                    c_d.ptr = start_addr[SLOT_W-1:0];
                    lat_clr = 1'b1;
                end else if (stop) begin
                    if (!wp && lat_any) begin
                        c_d.st    = PW_COMMIT;
                        tmr_start = 1'b1;
                    end else begin
                        c_d.st = PW_IDLE;
                    end
                end else if (byte_vld) begin
                    lat_wr  = 1'b1;
                    c_d.ptr = c_q.ptr + 1'b1;
                end
            end
            PW_COMMIT: begin
                if (tmr_last) c_d.st = PW_IDLE;
            end
            default: c_d.st = PW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: PW_IDLE, hi: '0, ptr: '0};
        else        c_q <= c_d;
    end

    pwb_page_latch #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (lat_clr),
        .wr_en     (lat_wr),
        .wr_slot   (c_q.ptr),
        .wr_data   (byte_data),
        .rd_slot   (tmr_slot),
        .rd_data   (lat_rd_data),
        .rd_valid  (lat_rd_valid),
        .any_valid (lat_any)
    );

    pwb_commit_timer #(
        .CYCLE_TICKS (CYCLE_TICKS),
        .PAGE_BYTES  (PAGE_BYTES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (tmr_start),
        .busy      (tmr_busy),
        .last      (tmr_last),
        .slot_live (tmr_live),
        .slot      (tmr_slot)
    );

    assign busy      = tmr_busy;
    assign arr_we    = tmr_live && lat_rd_valid;
    assign arr_addr  = {c_q.hi, tmr_slot};
    assign arr_wdata = lat_rd_data;

    // R4: array strobes only inside a commit cycle
    a_r4_we_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R6: a cycle begins only after an unprotected STOP
    a_r6_rise_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop && !wp));

    // R6: protected STOP in a session never starts a cycle
    a_r6_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == PW_FILL && !rstart && !cmd_start && stop && wp) |=> !busy);

    // R2: page number held for the whole cycle
    a_r2_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(arr_addr[ADDR_W-1:SLOT_W]));

    // R9: repeated START closes the session with no cycle
    a_r9_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == PW_FILL && rstart) |=> (!busy && c_q.st == PW_IDLE));

endmodule

// File: tb/pwb_page_commit_test.sv
module pwb_page_commit_test;

    localparam int CLK_PERIOD = 10;
    localparam int CYC        = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [12:0] start_addr = '0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        stop = 1'b0;
    logic        rstart = 1'b0;
    logic        wp = 1'b0;
    logic        arr_we;
    logic [12:0] arr_addr;
    logic [7:0]  arr_wdata;
    logic        busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwb_page_commit #(.CYCLE_TICKS(CYC)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_addr(start_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .stop(stop), .rstart(rstart),
        .wp(wp), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .busy(busy)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // write recorder
    int          busy_cnt = 0;
    int          rec_n = 0;
    logic [12:0] rec_addr [64];
    logic [7:0]  rec_data [64];
    int          rec_idx  [64];

    always @(posedge clk) begin
        if (arr_we && rec_n < 64) begin
            rec_addr[rec_n] <= arr_addr;
            rec_data[rec_n] <= arr_wdata;
            rec_idx[rec_n]  <= busy_cnt;
            rec_n           <= rec_n + 1;
        end
        if (busy) busy_cnt <= busy_cnt + 1;
    end

    typedef struct packed {
        logic [12:0] addr;
        logic [7:0]  n;
        logic [7:0]  seed;
        logic        wp;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{addr: 13'h0100, n: 8'd1,  seed: 8'h5A, wp: 1'b0},
        '{addr: 13'h1FFE, n: 8'd4,  seed: 8'h10, wp: 1'b0},
        '{addr: 13'h0A05, n: 8'd32, seed: 8'h33, wp: 1'b0},
        '{addr: 13'h0A05, n: 8'd35, seed: 8'hC1, wp: 1'b0},
        '{addr: 13'h0040, n: 8'd3,  seed: 8'h77, wp: 1'b1}
    };

    logic       exp_v [32];
    logic [7:0] exp_d [32];

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic clear_rec();
        @(negedge clk);
        rec_n = 0;
        busy_cnt = 0;
        for (int i = 0; i < 32; i++) begin
            exp_v[i] = 1'b0;
            exp_d[i] = '0;
        end
    endtask

    task automatic send_cmd(input logic [12:0] a);
        @(negedge clk);
        cmd_start = 1'b1; start_addr = a;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic send_bytes(input logic [12:0] a, input int n, input logic [7:0] seed, input bit track);
        for (int i = 0; i < n; i++) begin
            byte_vld = 1'b1;
            byte_data = 8'(seed + 8'(i * 7));
            if (track) begin
                exp_v[(int'(a[4:0]) + i) % 32] = 1'b1;
                exp_d[(int'(a[4:0]) + i) % 32] = 8'(seed + 8'(i * 7));
            end
            @(negedge clk);
        end
        byte_vld = 1'b0;
    endtask

    task automatic send_stop(input bit w);
        stop = 1'b1; wp = w;
        @(negedge clk);
        stop = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (CYC + 4) @(negedge clk);
    endtask

    task automatic compare_writes(input logic [12:0] a, input string tag);
        int j;
        int bad;
        j = 0;
        bad = 0;
        for (int k = 0; k < 32; k++) begin
            if (exp_v[k]) begin
                if (j >= rec_n || rec_addr[j] != {a[12:5], 5'(k)} ||
                    rec_data[j] != exp_d[k] || rec_idx[j] != k) bad++;
                j++;
            end
        end
        check(rec_n == j, {tag, " write count"}, rec_n, j);
        check(bad == 0, {tag, " write content/order"}, bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        check(arr_we == 1'b0, "R1 we in reset", arr_we, 0);
        rst_n = 1'b1;
        @(negedge clk);
        send_stop(1'b0);
        check(busy == 1'b0, "R1 no session after reset", busy, 0);

        // table-driven sessions: R2 R3 R5 R6 R8
        for (int v = 0; v < 5; v++) begin
            clear_rec();
            send_cmd(VECS[v].addr);
            send_bytes(VECS[v].addr, int'(VECS[v].n), VECS[v].seed, !VECS[v].wp);
            check(rec_n == 0, "R4 no write before stop", rec_n, 0);
            send_stop(VECS[v].wp);
            check(busy == !VECS[v].wp, "R5/R6 busy after stop", busy, !VECS[v].wp);
            wait_idle();
            check(busy_cnt == (VECS[v].wp ? 0 : CYC), "R5 busy length", busy_cnt, VECS[v].wp ? 0 : CYC);
            compare_writes(VECS[v].addr, "R2/R3/R8 vector");
        end

        // R6: protected stop then immediate new command is accepted
        clear_rec();
        send_cmd(13'h0300);
        send_bytes(13'h0300, 2, 8'h01, 1'b0);
        send_stop(1'b1);
        check(busy == 1'b0, "R6 protected no busy", busy, 0);
        cmd_start = 1'b1; start_addr = 13'h0320;
        @(negedge clk);
        cmd_start = 1'b0;
        send_bytes(13'h0320, 1, 8'hE4, 1'b1);
        send_stop(1'b0);
        wait_idle();
        check(busy_cnt == CYC, "R6 ready immediately", busy_cnt, CYC);
        compare_writes(13'h0320, "R6 follow-up");

        // R7: wp toggles during cycle
        clear_rec();
        send_cmd(13'h0450);
        send_bytes(13'h0450, 5, 8'h90, 1'b1);
        send_stop(1'b0);
        wp = 1'b1;
        repeat (3) @(negedge clk);
        wp = 1'b0;
        @(negedge clk);
        wp = 1'b1;
        wait_idle();
        wp = 1'b0;
        check(busy_cnt == CYC, "R7 cycle unaffected", busy_cnt, CYC);
        compare_writes(13'h0450, "R7 writes");

        // R9 repeated start discards; R8 later short session writes only its slots
        clear_rec();
        send_cmd(13'h0600);
        send_bytes(13'h0600, 10, 8'h22, 1'b0);
        @(negedge clk);
        rstart = 1'b1;
        @(negedge clk);
        rstart = 1'b0;
        send_stop(1'b0);
        wait_idle();
        check(busy_cnt == 0, "R9 discard no cycle", busy_cnt, 0);
        check(rec_n == 0, "R9 discard no write", rec_n, 0);
        clear_rec();
        send_cmd(13'h0604);
        send_bytes(13'h0604, 2, 8'hAB, 1'b1);
        send_stop(1'b0);
        wait_idle();
        compare_writes(13'h0604, "R8 mask cleared");

        // R10 traffic during busy ignored
        clear_rec();
        send_cmd(13'h0700);
        send_bytes(13'h0700, 3, 8'h40, 1'b1);
        send_stop(1'b0);
        send_cmd(13'h0800);
        send_bytes(13'h0800, 4, 8'h00, 1'b0);
        send_stop(1'b0);
        rstart = 1'b1;
        @(negedge clk);
        rstart = 1'b0;
        wait_idle();
        check(busy_cnt == CYC, "R10 busy not extended", busy_cnt, CYC);
        compare_writes(13'h0700, "R10 writes");
        clear_rec();
        send_stop(1'b0);
        wait_idle();
        check(busy_cnt == 0, "R10 stop without command", busy_cnt, 0);

        // R11 empty session
        clear_rec();
        send_cmd(13'h0900);
        send_stop(1'b0);
        check(busy == 1'b0, "R11 empty no busy", busy, 0);
        wait_idle();
        check(rec_n == 0, "R11 empty no write", rec_n, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule